// File: doc/BRIEF.md
# Four-Mode Timer Waveform Generator

A timer/counter with two compare channels. It drives a pair of waveform outputs in one of four modes: free-running frequency generation, frequency generation with the period set by compare channel 0, single-slope PWM, and PWM with the period set by compare channel 0. The counter counts up or down at 8, 16 or 32 bits of resolution. A prescaler divides the clock by a selectable power-of-two factor and gates the counter.

Software sets the block up through a write-only register port. Six word addresses hold control, period, the two compare values, an interrupt enable mask and a write-one-to-clear flag port. The block reports compare matches and counter wraps as sticky flags. An interrupt line is the OR of the flags that are enabled. A one-cycle DMA request pulse follows each compare match. The count value and the flags are brought out as plain outputs.

Top module: `tc_wavegen`

## Requirements
- R1: After synchronous reset `count_o`, `flags_o`, `wave_out`, `irq` and `dma_req` are all zero. The timer is stopped and every register holds zero.
- R2: Control bits [8:6] pick the divider: 0..7 give 1, 2, 4, 8, 16, 64, 256, 1024. After the enable bit (control bit 0) is written to 1 from a stopped state, the count goes up by one for each full divider period.
- R3: With control bit 5 clear, the counter counts up and goes to zero on the tick where it is at or above TOP. With bit 5 set, it counts down and reloads TOP on the tick where it is zero. A stopped timer holds count 0.
- R4: In modes 0 and 2, TOP is the 8-bit period register (address 1) when the resolution field (control bits [4:3]) is 0. For values 1, 2 and 3 of that field, TOP is the counter maximum (16-bit, 32-bit, 32-bit).
- R5: In modes 1 and 3, TOP is compare value 0 (address 2), masked to the resolution.
- R6: The mode field is control bits [2:1]. In mode 0 (normal frequency), output n toggles on every tick where the count equals compare value n.
- R7: In mode 1 (match frequency), output 0 toggles on every tick where TOP or zero is reached (the wrap tick), and output 1 toggles on its compare match.
- R8: In single-slope PWM (mode 2 for both outputs, mode 3 for output 1), counting up sets the output on the wrap tick and clears it on a match. Counting down clears it on the wrap tick and sets it on a match. The wrap tick wins a tie. While stopped, the output rests at 1 when counting up and 0 when counting down.
- R9: In mode 3 (match PWM), output 0 rests at 1. It drops to 0 for exactly one prescaled tick period after each wrap tick.
- R10: `flags_o` bit 0 is set by a wrap tick and bit n+1 by a compare match on channel n. Writing a one to a bit at address 5 clears that flag, and a new event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some flag is set whose bit in the enable mask (address 4, same bit positions) is set.
- R12: `dma_req` is high for one cycle following each tick on which any channel matched, and low otherwise.
- R13: Control bits [10:9] invert outputs 1 and 0 after waveform generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| wave_out | output | 2 | Waveform outputs after inversion |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA request per match tick |
| count_o | output | 32 | Current counter value |
| flags_o | output | 3 | Sticky flags: wrap, match 0, match 1 |

## Verification
The bench builds the block with its default parameters: a 32-bit counter datapath, an 8-bit period register and a 10-bit prescaler. This lets it reach all three resolutions and every divider up to 1024. Directed runs use the 16-bit resolution to show that the period register is ignored once the counter is wider than 8 bits, and they time the divide-by-64 and divide-by-1024 steps exactly. The random phase keeps TOP small, so a few hundred cycles per configuration wrap the counter many times in every mode and direction. In that phase, wrap, match and flag clears often fall on the same cycle.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    localparam int NCH      = 2;
    localparam int CNT_W    = 32;
    localparam int PER_W    = 8;
    localparam int PS_W     = 10;
    localparam int FLAG_W   = NCH + 1;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CC0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FCLR = 3'd5;

    typedef enum logic [1:0] {
        WG_NFRQ = 2'd0,
        WG_MFRQ = 2'd1,
        WG_NPWM = 2'd2,
        WG_MPWM = 2'd3
    } wg_mode_e;

    typedef enum logic [1:0] {
        RES_8   = 2'd0,
        RES_16  = 2'd1,
        RES_32  = 2'd2,
        RES_32B = 2'd3
    } res_e;

    typedef struct packed {
        logic [NCH-1:0] inv;
        logic [2:0]     psel;
        logic           down;
        res_e           res;
        wg_mode_e       mode;
        logic           en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [CNT_W-1:0] res_max(res_e r);
        case (r)
            RES_8:   res_max = CNT_W'(32'h0000_00FF);
            RES_16:  res_max = CNT_W'(32'h0000_FFFF);
            default: res_max = CNT_W'(32'hFFFF_FFFF);
        endcase
    endfunction

    function automatic logic [3:0] ps_shift(logic [2:0] sel);
        case (sel)
            3'd5:    ps_shift = 4'd6;
            3'd6:    ps_shift = 4'd8;
            3'd7:    ps_shift = 4'd10;
            default: ps_shift = {1'b0, sel};
        endcase
    endfunction

    function automatic logic is_match_mode(wg_mode_e m);
        is_match_mode = (m == WG_MFRQ) || (m == WG_MPWM);
    endfunction

endpackage

// File: rtl/tcw_prescaler.sv
module tcw_prescaler
    import tcw_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [W-1:0] ps_q;
    logic [W-1:0] lim;

    always_comb begin
        lim  = W'({W{1'b1}} >> (W - int'(ps_shift(sel))));
        tick = run && (ps_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) ps_q <= '0;
        else                     ps_q <= ps_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst) assert_ps_bound_R2: assert (ps_q <= lim || !run || $isunknown(sel))
            else $error("prescaler count passed its limit");
    end

    property p_tick_restarts;
        @(posedge clk) disable iff (rst) tick |=> (ps_q == '0);
    endproperty
    assert_tick_restart_R2: assert property (p_tick_restarts);

endmodule

// File: rtl/tcw_counter.sv
module tcw_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         down,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         upd
);
    always_comb upd = run && tick && (down ? (cnt == '0) : (cnt >= top));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick) begin
            if (upd)       cnt <= down ? top : '0;
            else if (down) cnt <= cnt - 1'b1;
            else           cnt <= cnt + 1'b1;
        end
    end

    property p_hold;
        @(posedge clk) disable iff (rst) (run && !tick) |=> $stable(cnt);
    endproperty
    assert_hold_between_ticks_R2: assert property (p_hold);

    property p_up_step;
        @(posedge clk) disable iff (rst) (run && tick && !down && cnt < top) |=> (cnt == $past(cnt) + 1'b1);
    endproperty
    assert_up_step_R3: assert property (p_up_step);

    property p_down_reload;
        @(posedge clk) disable iff (rst) (run && tick && down && cnt == '0) |=> (cnt == $past(top));
    endproperty
    assert_down_reload_R3: assert property (p_down_reload);

endmodule

// File: rtl/tcw_wave_ch.sv
module tcw_wave_ch
    import tcw_pkg::*;
#(
    parameter int W     = 32,
    parameter bit FIRST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         upd,
    input  logic         down,
    input  wg_mode_e     mode,
    input  logic [W-1:0] cc,
    input  logic [W-1:0] cnt,
    output logic         match,
    output logic         wave
);
    logic pwm_nxt;
    logic rest_val;

    always_comb begin
        match = run && tick && (cnt == cc);
        if (down) pwm_nxt = upd ? 1'b0 : (match ? 1'b1 : wave);
        else      pwm_nxt = upd ? 1'b1 : (match ? 1'b0 : wave);
        case (mode)
            WG_NPWM: rest_val = !down;
            WG_MPWM: rest_val = FIRST ? 1'b1 : !down;
            default: rest_val = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       wave <= 1'b0;
        else if (!run) wave <= rest_val;
        else begin
            case (mode)
                WG_NFRQ: if (match) wave <= !wave;
                WG_MFRQ: begin
                    if (FIRST) begin
                        if (upd) wave <= !wave;
                    end else if (match) wave <= !wave;
                end
                WG_NPWM: wave <= pwm_nxt;
                default: begin
                    if (FIRST) begin
                        if (upd)       wave <= 1'b0;
                        else if (tick) wave <= 1'b1;
                    end else wave <= pwm_nxt;
                end
            endcase
        end
    end

    property p_nfrq_toggle;
        @(posedge clk) disable iff (rst) (run && mode == WG_NFRQ && match) |=> (wave != $past(wave));
    endproperty
    assert_nfrq_toggle_R6: assert property (p_nfrq_toggle);

    property p_pwm_up_set;
        @(posedge clk) disable iff (rst) (run && mode == WG_NPWM && !down && upd) |=> wave;
    endproperty
    assert_pwm_up_set_R8: assert property (p_pwm_up_set);

    generate
        if (FIRST) begin : g_first
            property p_mpwm_pulse;
                @(posedge clk) disable iff (rst) (run && mode == WG_MPWM && upd) |=> !wave;
            endproperty
            assert_mpwm_pulse_R9: assert property (p_mpwm_pulse);
        end
    endgenerate

endmodule

// File: rtl/tc_wavegen.sv
module tc_wavegen
    import tcw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PER_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NCH-1:0]    wave_out,
    output logic              irq,
    output logic              dma_req,
    output logic [CW-1:0]     count_o,
    output logic [FLAG_W-1:0] flags_o
);
    ctrl_t              ctrl_q;
    logic [PW-1:0]      per_q;
    logic [CW-1:0]      cc_q [NCH];
    logic [FLAG_W-1:0]  ien_q;
    logic [FLAG_W-1:0]  flags_q;

    logic               tick;
    logic               upd;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      max_v;
    logic [CW-1:0]      top_v;
    logic [CW-1:0]      cc_m  [NCH];
    logic [NCH-1:0]     match;
    logic [NCH-1:0]     wave;
    logic [FLAG_W-1:0]  fl_set;
    logic [FLAG_W-1:0]  fl_clr;

    // register write port
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_PER:  per_q  <= wr_data[PW-1:0];
                A_IEN:  ien_q  <= wr_data[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) cc_q[gi] <= '0;
                else if (wr_en && wr_addr == A_CC0 + ADDR_W'(gi)) cc_q[gi] <= wr_data[CW-1:0];
            end

            assign cc_m[gi] = cc_q[gi] & max_v;

            tcw_wave_ch #(.W(CW), .FIRST(gi == 0)) u_ch (
                .clk   (clk),
                .rst   (rst),
                .run   (ctrl_q.en),
                .tick  (tick),
                .upd   (upd),
                .down  (ctrl_q.down),
                .mode  (ctrl_q.mode),
                .cc    (cc_m[gi]),
                .cnt   (cnt),
                .match (match[gi]),
                .wave  (wave[gi])
            );
        end
    endgenerate

    // TOP selection by mode and resolution
    always_comb begin
        max_v = res_max(ctrl_q.res);
        if (is_match_mode(ctrl_q.mode)) top_v = cc_m[0];
        else if (ctrl_q.res == RES_8)   top_v = CW'(per_q);
        else                            top_v = max_v;
    end

    tcw_prescaler u_ps (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.en),
        .sel  (ctrl_q.psel),
        .tick (tick)
    );

    tcw_counter #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.en),
        .tick (tick),
        .down (ctrl_q.down),
        .top  (top_v),
        .cnt  (cnt),
        .upd  (upd)
    );

    // sticky flags, write one to clear, events win
    always_comb begin
        fl_set = {match, upd};
        fl_clr = (wr_en && wr_addr == A_FCLR) ? wr_data[FLAG_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            dma_req <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~fl_clr) | fl_set;
            dma_req <= |match;
        end
    end

    assign irq      = |(flags_q & ien_q);
    assign wave_out = wave ^ ctrl_q.inv;
    assign count_o  = cnt;
    assign flags_o  = flags_q;

    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_fchk
            property p_w1c;
                @(posedge clk) disable iff (rst) (fl_clr[gi] && !fl_set[gi]) |=> !flags_o[gi];
            endproperty
            assert_w1c_R10: assert property (p_w1c);

            property p_set;
                @(posedge clk) disable iff (rst) fl_set[gi] |=> flags_o[gi];
            endproperty
            assert_set_wins_R10: assert property (p_set);
        end
    endgenerate

    property p_dma_hi;
        @(posedge clk) disable iff (rst) (|match) |=> dma_req;
    endproperty
    assert_dma_hi_R12: assert property (p_dma_hi);

    property p_dma_lo;
        @(posedge clk) disable iff (rst) !(|match) |=> !dma_req;
    endproperty
    assert_dma_lo_R12: assert property (p_dma_lo);

    property p_stopped;
        @(posedge clk) disable iff (rst) !ctrl_q.en |=> (count_o == '0);
    endproperty
    assert_stopped_zero_R3: assert property (p_stopped);

endmodule

// File: tb/sim_tc_wavegen.sv
`timescale 1ns/1ps
module sim_tc_wavegen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wave_out;
    logic        irq;
    logic        dma_req;
    logic [31:0] count_o;
    logic [2:0]  flags_o;

    int total = 0;
    int bad   = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tc_wavegen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wave_out(wave_out), .irq(irq), .dma_req(dma_req), .count_o(count_o), .flags_o(flags_o)
    );

    // ---------------- reference model from the requirements ----------------
    logic        m_en, m_down;
    logic [1:0]  m_mode, m_res, m_inv;
    logic [2:0]  m_psel;
    logic [7:0]  m_per;
    logic [31:0] m_cc0, m_cc1, m_cnt;
    logic [2:0]  m_ien, m_flags;
    logic [1:0]  m_w;
    logic        m_dma;
    int          m_ps;

    function automatic logic [31:0] f_max(logic [1:0] r);
        return (r == 2'd0) ? 32'hFF : (r == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int f_div(logic [2:0] s);
        case (s)
            3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
            3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
        endcase
    endfunction

    function automatic logic f_rest(int ch, logic [1:0] md, logic dn);
        if (md == 2'd2) return !dn;
        if (md == 2'd3) return (ch == 0) ? 1'b1 : !dn;
        return 1'b0;
    endfunction

    function automatic logic f_wave(int ch, logic w, logic [1:0] md, logic dn, logic u, logic m, logic t);
        logic p;
        p = dn ? (u ? 1'b0 : (m ? 1'b1 : w)) : (u ? 1'b1 : (m ? 1'b0 : w));
        case (md)
            2'd0: return m ? !w : w;
            2'd1: return (ch == 0) ? (u ? !w : w) : (m ? !w : w);
            2'd2: return p;
            default: return (ch == 0) ? (u ? 1'b0 : (t ? 1'b1 : w)) : p;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] mx, tp;
        logic tk, up_ev, mt0, mt1;
        if (rst) begin
            m_en = 0; m_down = 0; m_mode = 0; m_res = 0; m_inv = 0; m_psel = 0;
            m_per = 0; m_cc0 = 0; m_cc1 = 0; m_cnt = 0; m_ien = 0; m_flags = 0;
            m_w = 0; m_dma = 0; m_ps = 0;
        end else begin
            mx = f_max(m_res);
            if (m_mode[0])          tp = m_cc0 & mx;
            else if (m_res == 2'd0) tp = {24'd0, m_per};
            else                    tp = mx;
            tk    = m_en && (m_ps == f_div(m_psel) - 1);
            up_ev = tk && (m_down ? (m_cnt == 0) : (m_cnt >= tp));
            mt0   = tk && (m_cnt == (m_cc0 & mx));
            mt1   = tk && (m_cnt == (m_cc1 & mx));
            if (!m_en) begin
                m_cnt = 0; m_ps = 0;
                m_w[0] = f_rest(0, m_mode, m_down);
                m_w[1] = f_rest(1, m_mode, m_down);
            end else begin
                m_ps = tk ? 0 : m_ps + 1;
                m_w[0] = f_wave(0, m_w[0], m_mode, m_down, up_ev, mt0, tk);
                m_w[1] = f_wave(1, m_w[1], m_mode, m_down, up_ev, mt1, tk);
                if (tk) m_cnt = up_ev ? (m_down ? tp : 32'd0) : (m_down ? m_cnt - 1 : m_cnt + 1);
            end
            m_flags = (m_flags & ~((wr_en && wr_addr == 3'd5) ? wr_data[2:0] : 3'd0)) | {mt1, mt0, up_ev};
            m_dma   = mt0 | mt1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: {m_inv, m_psel, m_down, m_res, m_mode, m_en} = wr_data[10:0];
                    3'd1: m_per = wr_data[7:0];
                    3'd2: m_cc0 = wr_data;
                    3'd3: m_cc1 = wr_data;
                    3'd4: m_ien = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string wave_tag(logic [1:0] md, logic [1:0] iv);
        if (iv != 0) return "R13";
        case (md)
            2'd0: return "R6";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            chk("R3 count", count_o, m_cnt);
            chk("R10 flags", {29'd0, flags_o}, {29'd0, m_flags});
            chk("R11 irq", {31'd0, irq}, {31'd0, |(m_flags & m_ien)});
            chk("R12 dma", {31'd0, dma_req}, {31'd0, m_dma});
            chk({wave_tag(m_mode, m_inv), " wave"}, {30'd0, wave_out}, {30'd0, m_w ^ m_inv});
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_ctrl(logic en, logic [1:0] md, logic [1:0] rs, logic dn,
                                            logic [2:0] ps, logic [1:0] iv);
        return {21'd0, iv, ps, dn, rs, md, en};
    endfunction

    task automatic start(logic [1:0] md, logic [1:0] rs, logic dn, logic [2:0] ps, logic [1:0] iv,
                         logic [7:0] per, logic [31:0] c0, logic [31:0] c1);
        wr(3'd0, mk_ctrl(1'b0, md, rs, dn, ps, iv));
        wr(3'd1, {24'd0, per});
        wr(3'd2, c0);
        wr(3'd3, c1);
        wr(3'd5, 32'h7);
        wr(3'd0, mk_ctrl(1'b1, md, rs, dn, ps, iv));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count_o, 32'd0);
        chk("R1 flags", {29'd0, flags_o}, 32'd0);
        chk("R1 wave", {30'd0, wave_out}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 dma", {31'd0, dma_req}, 32'd0);
        chk_on = 1'b1;

        // R2 divide by 64 and by 1024
        start(2'd0, 2'd0, 1'b0, 3'd5, 2'd0, 8'd255, 32'd200, 32'd201);
        edges(191); chk("R2 div64 before step", count_o, 32'd2);
        edges(1);   chk("R2 div64 step", count_o, 32'd3);
        start(2'd0, 2'd0, 1'b0, 3'd7, 2'd0, 8'd255, 32'd200, 32'd201);
        edges(2047); chk("R2 div1024 before step", count_o, 32'd1);
        edges(1);    chk("R2 div1024 step", count_o, 32'd2);

        // R4 period used only at 8-bit resolution
        start(2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 8'd10, 32'd500, 32'd501);
        edges(300); chk("R4 8-bit wraps at period", count_o, 32'd3);
        start(2'd2, 2'd1, 1'b0, 3'd0, 2'd0, 8'd10, 32'd500, 32'd501);
        edges(300); chk("R4 16-bit ignores period", count_o, 32'd300);

        // R5 compare 0 is TOP in match modes
        start(2'd1, 2'd0, 1'b0, 3'd0, 2'd0, 8'd200, 32'd5, 32'd2);
        edges(20); chk("R5 top from cc0", count_o, 32'd2);

        // R3 down count reload
        start(2'd0, 2'd0, 1'b1, 3'd0, 2'd0, 8'd10, 32'd200, 32'd201);
        edges(1);  chk("R3 reload after zero", count_o, 32'd10);
        edges(10); chk("R3 down to zero", count_o, 32'd0);
        edges(1);  chk("R3 second reload", count_o, 32'd10);

        // R9 and R8 in match PWM
        start(2'd3, 2'd0, 1'b0, 3'd0, 2'd0, 8'd0, 32'd3, 32'd1);
        edges(2); chk("R8 out1 cleared on match", {31'd0, wave_out[1]}, 32'd0);
        edges(1); chk("R9 out0 high before wrap", {31'd0, wave_out[0]}, 32'd1);
        edges(1); chk("R9 out0 low pulse", {31'd0, wave_out[0]}, 32'd0);
                  chk("R8 out1 set on wrap", {31'd0, wave_out[1]}, 32'd1);
        edges(1); chk("R9 out0 pulse ends", {31'd0, wave_out[0]}, 32'd1);

        // R12 and R6 on channel 1 match
        start(2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 8'd255, 32'd200, 32'd2);
        edges(2); chk("R6 out1 before match", {31'd0, wave_out[1]}, 32'd0);
        edges(1); chk("R12 dma after match", {31'd0, dma_req}, 32'd1);
                  chk("R6 out1 toggled", {31'd0, wave_out[1]}, 32'd1);
        edges(1); chk("R12 dma one cycle", {31'd0, dma_req}, 32'd0);

        // R13 inversion on stopped outputs
        wr(3'd0, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 2'd3));
        edges(1); chk("R13 both inverted", {30'd0, wave_out}, 32'd3);

        // R11 and R10 interrupt from wrap flag and clear
        wr(3'd4, 32'd1);
        start(2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 8'd3, 32'd200, 32'd201);
        edges(3); chk("R11 irq before wrap", {31'd0, irq}, 32'd0);
        edges(1); chk("R11 irq after wrap", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'd0);
        wr(3'd5, 32'h7);
        chk("R10 flags cleared", {29'd0, flags_o}, 32'd0);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);

        // random configurations checked against the model
        for (int it = 0; it < 48; it++) begin
            logic [1:0] md, rs, iv;
            logic dn;
            md = 2'($urandom % 4);
            rs = md[0] ? 2'($urandom % 4) : 2'd0;
            dn = 1'($urandom % 2);
            iv = 2'($urandom % 4);
            wr(3'd4, 32'($urandom % 8));
            start(md, rs, dn, 3'($urandom % 3), iv, 8'($urandom % 16),
                  32'($urandom % 16), 32'($urandom % 16));
            for (int c = 0; c < 250; c++) begin
                if ($urandom % 16 == 0) wr(3'd5, 32'($urandom % 8));
                else @(negedge clk);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule